// File: doc/BRIEF.md
# Read Strobe Leveling Sweep Sequencer

This block drives a software-style read leveling pass over two byte slices of a DDR PHY. It sits between an initiator, which asks for a pass with a one-cycle `go` pulse, and a PHY control port made of plain level and pulse pins. The port carries the leveling mode code, the response edge select, the start, load and exit strobes, an operation-done return, one 4-bit leveling response per slice and one delay field per slice.

When a pass is requested, the sequencer first stores each slice's present delay as its fallback. It then selects read strobe-to-data leveling and opens the session with a start strobe. Next it sweeps slice 0 and then slice 1 through every delay tap. At each tap it writes the tap, strobes load, waits for done and grades the slice's response. A streaming edge tracker reduces the pass/fail sequence to the opening and closing edges of the data eye, filtering out short glitches. Each slice resolves to half the eye span, or to its stored fallback when no clean eye exists. Both results are then loaded together, and the session is closed with an exit strobe.

Every wait for the PHY is bounded by a programmable cycle limit. If the limit runs out, the pass is abandoned with an error flag. No data stream crosses the block's edge: the initiator side is a plain request/busy/done/error set and carries no back-pressure.

Top module: `lvl_read_sweep`

## Requirements
- R1: A `go` pulse seen while idle latches `phy_cur_dly0` and `phy_cur_dly1` as the slice fallbacks in that cycle, and `busy` is high from the next cycle until the pass ends. Later changes on those inputs have no effect on the result. `go` while busy is ignored.
- R2: A pass opens with exactly one start strobe, issued while `phy_mode` is 2'b10 and `phy_edge` is 0. No load strobe is issued before the done that answers it.
- R3: Slice 0 is swept with taps 0 to NTAPS-1 in rising order: each tap is placed on `phy_dly0`, zero-extended, in the cycle its load strobe is high. Slice 1 is then swept the same way on `phy_dly1`, and during that sweep `phy_dly0` stays at NTAPS-1.
- R4: A tap passes when the slice's own response (`phy_resp0` for slice 0, `phy_resp1` for slice 1) equals 4'h0 in the cycle done is accepted. Any other value, 1 to 15, is a fail.
- R5: The eye opening is the lowest tap i, with 4 <= i <= NTAPS-5, where tap i-1 fails and taps i, i+1, i+2 and i+3 all pass.
- R6: The eye closing is the lowest tap j >= the opening, with j <= NTAPS-5, where tap j fails and taps j-1, j-2 and j-3 all pass. It is only searched once an opening exists.
- R7: When both edges exist, the slice result is floor((closing - opening) / 2).
- R8: When either edge is missing, the slice result is the fallback latched at `go`.
- R9: After slice 1 resolves, both results are placed on `phy_dly0`/`phy_dly1` with one load strobe. After that done, one exit strobe follows. After the exit's done, `done` pulses for one cycle with `err` low.
- R10: Start, load and exit strobes are each one cycle wide, and no two are high together.
- R11: In each wait, `phy_op_done` is accepted on wait cycles 0 to `tmo_limit`, counting from the cycle the strobe is high. If none arrives, `err` rises, `busy` falls and no further strobe or `done` is issued.
- R12: `err` stays high until the next accepted `go`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | One-cycle request to run a leveling pass |
| tmo_limit | input | TMO_W | Last wait cycle on which operation-done is accepted |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | Pass abandoned on a wait timeout |
| phy_mode | output | 2 | Leveling mode code, 2'b10 for read strobe-to-data |
| phy_edge | output | 1 | Response edge select, held at 0 |
| phy_start | output | 1 | Session start strobe |
| phy_load | output | 1 | Delay load strobe |
| phy_exit | output | 1 | Session exit strobe |
| phy_op_done | input | 1 | Operation-done return from the PHY |
| phy_resp0 | input | RESP_W | Leveling response of slice 0 |
| phy_resp1 | input | RESP_W | Leveling response of slice 1 |
| phy_cur_dly0 | input | DLY_W | Present delay of slice 0, latched as fallback |
| phy_cur_dly1 | input | DLY_W | Present delay of slice 1, latched as fallback |
| phy_dly0 | output | DLY_W | Delay field driven to slice 0 |
| phy_dly1 | output | DLY_W | Delay field driven to slice 1 |

## Verification
The bench sweeps many eye positions and widths against a behavioural search. It places eyes that open exactly at tap 4 or at tap 3, that close exactly at tap NTAPS-5 or one beyond, that are empty, fully open, preceded by a short glitch or split by a one-tap hole. A design with an off-by-one scan limit, a missing glitch filter or an edge search started at the wrong place would return a wrong delay, or the fallback where an eye exists. Fail codes vary across 1 to 15, so a design that tests only one response bit, or reads the other slice's field, resolves the wrong eye. Done latencies equal to and one past the timeout limit, a dropped done in the middle of slice 1, and a `go` during a pass probe the wait window, the abandon path and request filtering. A design that misses these would hang, strobe twice or still report completion.

// File: rtl/lvl_sweep_pkg.sv
package lvl_sweep_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_W_START,
    ST_LOAD,
    ST_W_LOAD,
    ST_RESOLVE,
    ST_FIN_LOAD,
    ST_W_FIN,
    ST_EXIT,
    ST_W_EXIT
  } sweep_st_t;

  localparam logic [1:0] MODE_RD_STROBE = 2'b10;
  localparam int         NUM_SLICES     = 2;
  localparam int         RISE_RUN       = 4;

endpackage

// File: rtl/lvl_wait_timer.sv
module lvl_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  localparam logic [TMO_W-1:0] CNT_MAX = '1;

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == limit);

  // R11: every wait window starts counting from zero
  p_window_fresh_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/lvl_eye_track.sv
module lvl_eye_track #(
  parameter int NTAPS = 256,
  parameter int IDX_W = $clog2(NTAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             smp_vld,
  input  logic             smp_pass,
  input  logic [IDX_W-1:0] smp_idx,
  output logic             eye_found,
  output logic [IDX_W-1:0] eye_half
);

  // Opening candidate i is confirmed when tap i+3 arrives.
  localparam logic [IDX_W-1:0] RISE_J_LO = IDX_W'(7);
  localparam logic [IDX_W-1:0] RISE_J_HI = IDX_W'(NTAPS - 2);
  localparam logic [IDX_W-1:0] FALL_J_HI = IDX_W'(NTAPS - 5);
  localparam logic [IDX_W-1:0] RUN_BACK  = IDX_W'(3);

  logic [3:0]       hist_q;   // hist_q[k] = grade of tap (current - 1 - k)
  logic             rise_q, fall_q;
  logic [IDX_W-1:0] open_q, close_q;
  logic             rise_hit, fall_hit;

  assign rise_hit = smp_vld && !rise_q && smp_pass && hist_q[0] && hist_q[1] &&
                    hist_q[2] && !hist_q[3] &&
                    (smp_idx >= RISE_J_LO) && (smp_idx <= RISE_J_HI);

  assign fall_hit = smp_vld && rise_q && !fall_q && !smp_pass && hist_q[0] &&
                    hist_q[1] && hist_q[2] && (smp_idx <= FALL_J_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      open_q  <= '0;
      close_q <= '0;
    end else if (clear) begin
      hist_q  <= '0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
      open_q  <= '0;
      close_q <= '0;
    end else if (smp_vld) begin
      hist_q <= {hist_q[2:0], smp_pass};
      if (rise_hit) begin
        rise_q <= 1'b1;
        open_q <= smp_idx - RUN_BACK;
      end
      if (fall_hit) begin
        fall_q  <= 1'b1;
        close_q <= smp_idx;
      end
    end
  end

  assign eye_found = rise_q && fall_q;
  assign eye_half  = (close_q - open_q) >> 1;

  // R6: a closing edge is never recorded without an opening
  p_close_needs_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> rise_q);

  // R7: the closing edge lies strictly above the opening
  p_eye_ordered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (close_q > open_q));

  // R5: a recorded opening never moves within one sweep
  p_open_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_q && !clear) |=> $stable(open_q));

endmodule

// File: rtl/lvl_read_sweep.sv
module lvl_read_sweep
  import lvl_sweep_pkg::*;
#(
  parameter int NTAPS  = 256,
  parameter int DLY_W  = 16,
  parameter int TMO_W  = 16,
  parameter int RESP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        phy_mode,
  output logic              phy_edge,
  output logic              phy_start,
  output logic              phy_load,
  output logic              phy_exit,
  input  logic              phy_op_done,
  input  logic [RESP_W-1:0] phy_resp0,
  input  logic [RESP_W-1:0] phy_resp1,
  input  logic [DLY_W-1:0]  phy_cur_dly0,
  input  logic [DLY_W-1:0]  phy_cur_dly1,
  output logic [DLY_W-1:0]  phy_dly0,
  output logic [DLY_W-1:0]  phy_dly1
);

  localparam int               IDX_W    = $clog2(NTAPS);
  localparam logic [IDX_W-1:0] LAST_TAP = IDX_W'(NTAPS - 1);

  sweep_st_t        st_q;
  logic             slice_q;
  logic [IDX_W-1:0] tap_q;
  logic [DLY_W-1:0] def_q [NUM_SLICES];
  logic [DLY_W-1:0] res_q [NUM_SLICES];
  logic [DLY_W-1:0] dly_q [NUM_SLICES];
  logic [RESP_W-1:0] resp_arr [NUM_SLICES];
  logic [DLY_W-1:0] cur_arr  [NUM_SLICES];
  logic             found    [NUM_SLICES];
  logic [IDX_W-1:0] half     [NUM_SLICES];

  logic start_q, load_q, exit_q, done_q, err_q;
  logic [1:0] mode_q;
  logic       edge_q;

  logic go_acc;
  logic in_wait;
  logic tmo_exp;

  assign resp_arr[0] = phy_resp0;
  assign resp_arr[1] = phy_resp1;
  assign cur_arr[0]  = phy_cur_dly0;
  assign cur_arr[1]  = phy_cur_dly1;

  assign go_acc  = (st_q == ST_IDLE) && go;
  assign in_wait = (st_q == ST_W_START) || (st_q == ST_W_LOAD) ||
                   (st_q == ST_W_FIN)   || (st_q == ST_W_EXIT);

  lvl_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (in_wait),
    .limit   (tmo_limit),
    .expired (tmo_exp)
  );

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    logic trk_vld;
    logic trk_pass;

    assign trk_vld  = (st_q == ST_W_LOAD) && phy_op_done && (slice_q == g[0]);
    assign trk_pass = (resp_arr[g] == '0);

    lvl_eye_track #(.NTAPS(NTAPS), .IDX_W(IDX_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (go_acc),
      .smp_vld   (trk_vld),
      .smp_pass  (trk_pass),
      .smp_idx   (tap_q),
      .eye_found (found[g]),
      .eye_half  (half[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        def_q[g] <= '0;
        res_q[g] <= '0;
      end else begin
        if (go_acc) begin
          def_q[g] <= cur_arr[g];
        end
        if ((st_q == ST_RESOLVE) && (slice_q == g[0])) begin
          res_q[g] <= found[g] ? DLY_W'(half[g]) : def_q[g];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      slice_q  <= 1'b0;
      tap_q    <= '0;
      start_q  <= 1'b0;
      load_q   <= 1'b0;
      exit_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      mode_q   <= 2'b00;
      edge_q   <= 1'b0;
      dly_q[0] <= '0;
      dly_q[1] <= '0;
    end else begin
      start_q <= 1'b0;
      load_q  <= 1'b0;
      exit_q  <= 1'b0;
      done_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (go) begin
            err_q   <= 1'b0;
            mode_q  <= MODE_RD_STROBE;
            edge_q  <= 1'b0;
            slice_q <= 1'b0;
            tap_q   <= '0;
            st_q    <= ST_START;
          end
        end
        ST_START: begin
          start_q <= 1'b1;
          st_q    <= ST_W_START;
        end
        ST_W_START: begin
          if (phy_op_done) begin
            st_q <= ST_LOAD;
          end else if (tmo_exp) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_LOAD: begin
          dly_q[slice_q] <= DLY_W'(tap_q);
          load_q         <= 1'b1;
          st_q           <= ST_W_LOAD;
        end
        ST_W_LOAD: begin
          if (phy_op_done) begin
            if (tap_q == LAST_TAP) begin
              st_q <= ST_RESOLVE;
            end else begin
              tap_q <= tap_q + 1'b1;
              st_q  <= ST_LOAD;
            end
          end else if (tmo_exp) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_RESOLVE: begin
          if (!slice_q) begin
            slice_q <= 1'b1;
            tap_q   <= '0;
            st_q    <= ST_LOAD;
          end else begin
            st_q <= ST_FIN_LOAD;
          end
        end
        ST_FIN_LOAD: begin
          dly_q[0] <= res_q[0];
          dly_q[1] <= res_q[1];
          load_q   <= 1'b1;
          st_q     <= ST_W_FIN;
        end
        ST_W_FIN: begin
          if (phy_op_done) begin
            st_q <= ST_EXIT;
          end else if (tmo_exp) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_EXIT: begin
          exit_q <= 1'b1;
          st_q   <= ST_W_EXIT;
        end
        ST_W_EXIT: begin
          if (phy_op_done) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (tmo_exp) begin
            err_q <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign phy_mode  = mode_q;
  assign phy_edge  = edge_q;
  assign phy_start = start_q;
  assign phy_load  = load_q;
  assign phy_exit  = exit_q;
  assign phy_dly0  = dly_q[0];
  assign phy_dly1  = dly_q[1];

  // R10: strobes last one cycle and never overlap
  p_start_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phy_start |=> !phy_start);
  p_load_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phy_load |=> !phy_load);
  p_exit_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phy_exit |=> !phy_exit);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_start, phy_load, phy_exit}));

  // R2: the session opens with the read strobe-to-data mode and edge 0
  p_start_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_start |-> (phy_mode == MODE_RD_STROBE) && !phy_edge);

  // R11: an expired wait abandons the pass with the error flag
  p_timeout_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_exp && !phy_op_done) |=> (!busy && err));

  // R9: completion is reported only clean and idle
  p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!err && !busy));

  // R1: an accepted request makes the block busy on the next cycle
  p_go_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> busy);

endmodule

// File: tb/lvl_read_sweep_bench.sv
module lvl_read_sweep_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N   = 32;
  localparam int IW  = $clog2(N);
  localparam int DW  = 16;
  localparam int TW  = 8;
  localparam int RW  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          go = 1'b0;
  logic [TW-1:0] tmo_limit = '0;
  logic          busy, done, err;
  logic [1:0]    phy_mode;
  logic          phy_edge, phy_start, phy_load, phy_exit;
  logic          phy_op_done = 1'b0;
  logic [RW-1:0] phy_resp0, phy_resp1;
  logic [DW-1:0] phy_cur_dly0 = '0, phy_cur_dly1 = '0;
  logic [DW-1:0] phy_dly0, phy_dly1;

  lvl_read_sweep #(.NTAPS(N), .DLY_W(DW), .TMO_W(TW), .RESP_W(RW)) u_lvl_read_sweep (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .tmo_limit    (tmo_limit),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .phy_mode     (phy_mode),
    .phy_edge     (phy_edge),
    .phy_start    (phy_start),
    .phy_load     (phy_load),
    .phy_exit     (phy_exit),
    .phy_op_done  (phy_op_done),
    .phy_resp0    (phy_resp0),
    .phy_resp1    (phy_resp1),
    .phy_cur_dly0 (phy_cur_dly0),
    .phy_cur_dly1 (phy_cur_dly1),
    .phy_dly0     (phy_dly0),
    .phy_dly1     (phy_dly1)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // PHY model configuration
  logic [N-1:0] pat0 = '0, pat1 = '0;
  int lat_cfg = 1;
  int drop_at = -1;
  int cd = -1;
  int pulse_no = 0;

  // monitor state
  int n_start = 0, n_load = 0, n_exit = 0, seq_bad = 0;
  bit done_seen = 1'b0;
  int exp0 = 0, exp1 = 0;

  function automatic logic [RW-1:0] fail_code(input logic [DW-1:0] d);
    return RW'((d % 15) + 1);
  endfunction

  always_comb begin
    phy_resp0 = (phy_dly0 < DW'(N) && pat0[phy_dly0[IW-1:0]]) ? '0 : fail_code(phy_dly0);
    phy_resp1 = (phy_dly1 < DW'(N) && pat1[phy_dly1[IW-1:0]]) ? '0 : fail_code(phy_dly1 + 16'd5);
  end

  // PHY done model: done appears lat_cfg cycles after the strobe cycle
  always @(negedge clk) begin
    if (phy_start || phy_load || phy_exit) begin
      cd = (pulse_no == drop_at) ? -1 : lat_cfg;
      pulse_no = pulse_no + 1;
    end else if (cd >= 0) begin
      cd = cd - 1;
    end
    phy_op_done = (cd == 0);
  end

  // sequence monitor (R2, R3, R9)
  always @(negedge clk) begin
    if (phy_start) begin
      n_start = n_start + 1;
      if (phy_mode != 2'b10 || phy_edge) seq_bad = seq_bad + 1;
    end
    if (phy_load) begin
      if (n_start != 1) seq_bad = seq_bad + 1;
      if (n_load < N) begin
        if (phy_dly0 != DW'(n_load)) seq_bad = seq_bad + 1;
      end else if (n_load < 2 * N) begin
        if (phy_dly1 != DW'(n_load - N) || phy_dly0 != DW'(N - 1)) seq_bad = seq_bad + 1;
      end else begin
        if (phy_dly0 != DW'(exp0) || phy_dly1 != DW'(exp1)) seq_bad = seq_bad + 1;
      end
      n_load = n_load + 1;
    end
    if (phy_exit) begin
      n_exit = n_exit + 1;
      if (n_load != 2 * N + 1) seq_bad = seq_bad + 1;
    end
    if (done) done_seen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [N-1:0] eye(input int lo, input int hi);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) v[i] = (i >= lo) && (i < hi);
    return v;
  endfunction

  // behavioural search from R5..R8
  function automatic int ref_dly(input logic [N-1:0] v, input int dflt);
    int lo = -1;
    int hi = -1;
    for (int i = 4; i <= N - 5; i++)
      if (lo < 0 && v[i] && !v[i-1] && v[i+1] && v[i+2] && v[i+3]) lo = i;
    if (lo >= 0)
      for (int i = lo; i <= N - 5; i++)
        if (hi < 0 && !v[i] && v[i-1] && v[i-2] && v[i-3]) hi = i;
    return (lo >= 0 && hi >= 0) ? (hi - lo) / 2 : dflt;
  endfunction

  int run_id = 0;

  task automatic run_case(input logic [N-1:0] v0, input logic [N-1:0] v1,
                          input int lat, input int tmo, input int drop,
                          input bit go_twice, input bit want_err);
    int d0, d1;
    bit finished;
    run_id++;
    d0 = 16'h0100 + run_id;
    d1 = 16'h0200 + 3 * run_id;
    pat0 = v0; pat1 = v1;
    lat_cfg = lat; drop_at = drop;
    tmo_limit = TW'(tmo);
    phy_cur_dly0 = DW'(d0);
    phy_cur_dly1 = DW'(d1);
    exp0 = ref_dly(v0, d0);
    exp1 = ref_dly(v1, d1);
    @(negedge clk);
    pulse_no = 0; n_start = 0; n_load = 0; n_exit = 0; seq_bad = 0; done_seen = 1'b0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    phy_cur_dly0 = ~phy_cur_dly0;   // R1: late changes must not matter
    phy_cur_dly1 = ~phy_cur_dly1;
    check(busy == 1'b1, "R1", "busy after go", int'(busy), 1);
    check(err == 1'b0, "R12", "err cleared by go", int'(err), 0);
    if (go_twice) begin
      repeat (20) @(negedge clk);
      go = 1'b1;
      @(negedge clk);
      go = 1'b0;
    end
    finished = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (!busy) begin
        finished = 1'b1;
        break;
      end
    end
    @(negedge clk);
    check(finished, "R11", "pass ended (watchdog)", int'(finished), 1);
    check(n_start == 1, "R2", "start strobe count", n_start, 1);
    check(seq_bad == 0, "R3", "strobe/delay sequence errors", seq_bad, 0);
    if (!want_err) begin
      check(err == 1'b0, "R11", "err after clean pass", int'(err), 0);
      check(done_seen, "R9", "done pulse seen", int'(done_seen), 1);
      check(n_load == 2 * N + 1, "R3", "load strobe count", n_load, 2 * N + 1);
      check(n_exit == 1, "R9", "exit strobe count", n_exit, 1);
      check(phy_dly0 == DW'(exp0), "R4 R5 R6 R7 R8", "slice0 delay", int'(phy_dly0), exp0);
      check(phy_dly1 == DW'(exp1), "R4 R5 R6 R7 R8", "slice1 delay", int'(phy_dly1), exp1);
    end else begin
      check(err == 1'b1, "R11", "err after timeout", int'(err), 1);
      check(!done_seen, "R11", "no done after timeout", int'(done_seen), 0);
      check(n_exit == 0, "R11", "no exit after timeout", n_exit, 0);
      check(busy == 1'b0, "R11", "idle after timeout", int'(busy), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] g;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1", "reset status",
          int'({busy, done, err}), 0);
    check(!phy_start && !phy_load && !phy_exit, "R10", "reset strobes",
          int'({phy_start, phy_load, phy_exit}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R6 R7: eye positions and widths
    foreach (g[k]) g[k] = 1'b0;
    for (int a = 4; a <= 12; a += 4) begin
      for (int w = 4; w <= 12; w += 4) begin
        run_case(eye(a, a + w), eye(a + 3, a + 5 + w), 2, 4, -1, 1'b0, 1'b0);
      end
    end
    // R8: empty, fully open, eye starting below tap 4
    run_case('0, '1, 1, 3, -1, 1'b0, 1'b0);
    run_case(eye(0, 10), eye(3, 12), 1, 3, -1, 1'b0, 1'b0);
    // R6 boundary: closing at NTAPS-5 and one beyond
    run_case(eye(18, 27), eye(19, 28), 1, 3, -1, 1'b0, 1'b0);
    // R5: short glitch before the eye; R6: one-tap hole inside it
    g = eye(12, 21) | eye(5, 7);
    run_case(g, eye(8, 25) & ~eye(15, 16), 1, 3, -1, 1'b0, 1'b0);
    // R11: done latency equal to the limit, and zero/zero
    run_case(eye(6, 16), eye(9, 20), 3, 3, -1, 1'b0, 1'b0);
    run_case(eye(7, 17), eye(10, 19), 0, 0, -1, 1'b0, 1'b0);
    // R11: latency one past the limit aborts at start
    run_case(eye(6, 16), eye(9, 20), 4, 3, -1, 1'b0, 1'b1);
    check(n_load == 0, "R2", "no load after failed start", n_load, 0);
    // R11: dropped done in the middle of slice 1
    run_case(eye(6, 16), eye(9, 20), 1, 5, 40, 1'b0, 1'b1);
    // R12: clean pass after an error; R1: go while busy ignored
    run_case(eye(5, 14), eye(11, 22), 1, 3, -1, 1'b1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule